// File: doc/BRIEF.md
# Edge-Counted Serial Command Front End

This block is the serial front end of a sixteen-channel grayscale LED driver. Three serial inputs come in: a data bit, a shift clock and a latch line. One data bit goes out. The block runs on the chip's system clock and treats the serial clock and latch as level inputs that are already synchronised. It finds their edges by comparing each input with a registered copy. While the latch line is low, each rising serial-clock edge shifts one bit into a shift register. The last bit of that register drives the serial output, so several drivers can be chained.

While the latch line is high, the block does not shift. It counts the rising serial-clock edges instead. When the latch line falls, that count selects one command:

| Edges while latch is high | Command |
|---|---|
| 1 | store one grayscale word |
| 2 or 3 | publish the grayscale frame |
| 4 or 5 | read back the configuration |
| 6 or 7 | start LED fault detection |
| 8 or 9 | read back per-channel health |
| 10 or 11 | write the configuration |
| 12 or 13 | return to the short shift length |

The shift register is 16 bits long in short mode. In long mode it is 256 bits long, one word per channel. The block holds the 16-bit configuration register and a sixteen-word grayscale buffer. It hands the published frame and a one-cycle commit strobe to the PWM engine, and a one-cycle start strobe to the fault detector.

Top module: `ledser_front`

## Requirements
- R1: A command is decoded only from the count of rising serial-clock edges seen while the latch line is high, and acts on the system-clock edge at which the latch line is first seen low. The count saturates at its maximum. Counts map to commands as follows: 1 stores a word; 2–3 publish the frame; 4–5 read the configuration; 6–7 start fault detection; 8–9 read channel health; 10–11 write the configuration; 12–13 force short mode.
- R2: While the latch line is low, each rising serial-clock edge shifts the data input into bit 0. The serial output is bit 15 in short mode and bit 255 in long mode, so a bit comes out after 16 or 256 further edges.
- R3: In short mode, a store-word command writes the low 16 shift bits into the buffer slot the slot pointer names. The pointer starts at channel 15 and counts down, wrapping from 0 to 15. In long mode a store-word command changes nothing.
- R4: In short mode, a publish command writes the low 16 shift bits into the current slot and presents the whole buffer on `frame_o`. Channel k occupies bits [16k+15:16k]. The command also pulses `commit_o` for one cycle, in the cycle after the latch falls, and resets the slot pointer to 15. Between publish commands, `frame_o` holds its value.
- R5: In long mode, a publish command loads all sixteen words at once: channel k takes shift bits [16k+15:16k]. The first word shifted in therefore lands on channel 15. The command also pulses `commit_o` and resets the pointer.
- R6: A configuration write copies the low 16 shift bits into the configuration register, all except bit 14. The register resets to 16'h06AC: bit 15 (long mode) is 0, bit 13 (16-bit counter) is 0, bits 12–11 (PWM mode) are 00, bit 10 (manual sync) is 1, bits 9–2 (gain) are 8'hAB, bit 1 (thermal shutdown enable) is 0, and bit 0 (timeout disable) is 0.
- R7: A configuration read places the configuration value, as seen on `cfg_o`, at the top of the active shift length: bits [15:0] in short mode, bits [255:240] in long mode. It then leaves MSB first on the serial output.
- R8: A health read places `chan_good_i` at the top of the active shift length the same way. Channel 15 leaves first. A 1 marks a good channel and a 0 marks an open or shorted one.
- R9: A fault-detect command pulses `diag_start_o` for exactly one cycle, in the cycle after the latch falls.
- R10: A force-short command clears configuration bit 15 and leaves every other configuration bit unchanged.
- R11: Configuration bit 14 cannot be written. On `cfg_o` and in configuration reads, it always shows the live `thermal_i` input.
- R12: An edge count of 0, 14 or 15 changes nothing: the configuration, the buffer, the published frame and the shift register all stay as they were, and no strobe fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial shift clock (synchronised level) |
| ser_latch | input | 1 | Latch / command line (synchronised level) |
| ser_din | input | 1 | Serial data in |
| ser_dout | output | 1 | Serial data out, toward the next driver in the chain |
| thermal_i | input | 1 | Live over-temperature flag |
| chan_good_i | input | CHANNELS | Per-channel health, 1 = good |
| cfg_o | output | 16 | Configuration value with the live thermal flag in bit 14 |
| frame_o | output | CHANNELS*WORD_W | Published grayscale frame, channel k at [16k+15:16k] |
| commit_o | output | 1 | One-cycle strobe when a new frame is published |
| diag_start_o | output | 1 | One-cycle strobe that starts fault detection |

## Verification
The assertions assume three things about the inputs. A rising serial-clock edge never arrives in the same system cycle as the latch line falls. No two latch falls come in back-to-back cycles. `chan_good_i` holds still while a command is decoded. The bench keeps within these limits because it changes each serial input only at a falling system-clock edge, holds every serial level for at least one full system cycle, and changes the thermal flag and health vector only between operations. On top of directed cases that cover both shift lengths and every edge count, random operations mix word shifts, random edge counts from 0 to 15 and random configuration writes. The configuration writes switch between the two shift lengths.

// File: rtl/ledser_pkg.sv
package ledser_pkg;

    localparam int CH_N   = 16;
    localparam int WORD_N = 16;
    localparam int CNT_W  = 4;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_STORE,
        CMD_PUBLISH,
        CMD_RD_CFG,
        CMD_DIAG,
        CMD_RD_HEALTH,
        CMD_WR_CFG,
        CMD_SHORT
    } ser_cmd_e;

    typedef struct packed {
        logic       long_sr;
        logic       therm;
        logic       pwm16;
        logic [1:0] pwm_mode;
        logic       manual_sync;
        logic [7:0] gain;
        logic       tsd_en;
        logic       tmo_off;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{
        long_sr:     1'b0,
        therm:       1'b0,
        pwm16:       1'b0,
        pwm_mode:    2'b00,
        manual_sync: 1'b1,
        gain:        8'hAB,
        tsd_en:      1'b0,
        tmo_off:     1'b0
    };

    function automatic ser_cmd_e decode_count(input logic [CNT_W-1:0] n);
        ser_cmd_e c;
        case (n)
            4'd1:         c = CMD_STORE;
            4'd2, 4'd3:   c = CMD_PUBLISH;
            4'd4, 4'd5:   c = CMD_RD_CFG;
            4'd6, 4'd7:   c = CMD_DIAG;
            4'd8, 4'd9:   c = CMD_RD_HEALTH;
            4'd10, 4'd11: c = CMD_WR_CFG;
            4'd12, 4'd13: c = CMD_SHORT;
            default:      c = CMD_NONE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/ledser_cmd_count.sv
module ledser_cmd_count
    import ledser_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     latch_lvl,
    input  logic     edge_rise,
    input  logic     latch_fall,
    output ser_cmd_e cmd_o
);
    localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (latch_fall) begin
            cnt_q <= '0;
        end else if (latch_lvl && edge_rise && cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        cmd_o = latch_fall ? decode_count(CNT_W'(cnt_q)) : CMD_NONE;
    end

    AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (rst)
        (latch_lvl && edge_rise && !latch_fall && cnt_q == CNT_MAX) |=> cnt_q == CNT_MAX); // R1
    AST_CNT_CLEARS: assert property (@(posedge clk) disable iff (rst)
        latch_fall |=> cnt_q == '0); // R1

endmodule

// File: rtl/ledser_shift.sv
module ledser_shift #(
    parameter int W  = 16,
    parameter int CH = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            long_mode,
    input  logic            shift_en,
    input  logic            din,
    input  logic            load_en,
    input  logic [W-1:0]    load_data,
    output logic [CH*W-1:0] sr_o,
    output logic            dout
);
    localparam int L = CH * W;

    logic [L-1:0] sr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q <= '0;
        end else if (load_en) begin
            if (long_mode) sr_q[L-1 -: W] <= load_data;
            else           sr_q[W-1:0]    <= load_data;
        end else if (shift_en) begin
            sr_q <= {sr_q[L-2:0], din};
        end
    end

    assign sr_o = sr_q;
    assign dout = long_mode ? sr_q[L-1] : sr_q[W-1];

    AST_SHIFT_ENTERS: assert property (@(posedge clk) disable iff (rst)
        (shift_en && !load_en) |=> sr_q[0] == $past(din)); // R2
    AST_SHIFT_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!shift_en && !load_en) |=> $stable(sr_q)); // R12

endmodule

// File: rtl/ledser_gsbuf.sv
module ledser_gsbuf #(
    parameter int W  = 16,
    parameter int CH = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            long_mode,
    input  logic            store,
    input  logic            publish,
    input  logic [W-1:0]    word_in,
    input  logic [CH*W-1:0] frame_in,
    output logic [CH*W-1:0] frame_o,
    output logic            commit_o
);
    localparam int PW = (CH > 1) ? $clog2(CH) : 1;
    localparam logic [PW-1:0] TOP_SLOT = PW'(CH - 1);

    logic [CH-1:0][W-1:0] buf_q, frame_q, buf_nx;
    logic [PW-1:0]        ptr_q;
    logic                 commit_q;

    for (genvar k = 0; k < CH; k++) begin : g_slot
        always_comb begin
            buf_nx[k] = buf_q[k];
            if (!long_mode && (store || publish) && ptr_q == PW'(k))
                buf_nx[k] = word_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_q    <= '0;
            frame_q  <= '0;
            ptr_q    <= TOP_SLOT;
            commit_q <= 1'b0;
        end else if (publish) begin
            ptr_q    <= TOP_SLOT;
            commit_q <= 1'b1;
            if (long_mode) begin
                buf_q   <= frame_in;
                frame_q <= frame_in;
            end else begin
                buf_q   <= buf_nx;
                frame_q <= buf_nx;
            end
        end else begin
            commit_q <= 1'b0;
            if (store && !long_mode) begin
                buf_q <= buf_nx;
                ptr_q <= (ptr_q == '0) ? TOP_SLOT : ptr_q - 1'b1;
            end
        end
    end

    assign frame_o  = frame_q;
    assign commit_o = commit_q;

    AST_PTR_RESTART: assert property (@(posedge clk) disable iff (rst)
        publish |=> ptr_q == TOP_SLOT); // R4
    AST_FRAME_HOLD: assert property (@(posedge clk) disable iff (rst)
        !publish |=> $stable(frame_q)); // R4
    AST_LONG_STORE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (store && long_mode && !publish) |=> $stable(buf_q) && $stable(ptr_q)); // R3

endmodule

// File: rtl/ledser_front.sv
module ledser_front
    import ledser_pkg::*;
#(
    parameter int CHANNELS = CH_N,
    parameter int WORD_W   = WORD_N
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     ser_clk,
    input  logic                     ser_latch,
    input  logic                     ser_din,
    output logic                     ser_dout,
    input  logic                     thermal_i,
    input  logic [CHANNELS-1:0]      chan_good_i,
    output logic [15:0]              cfg_o,
    output logic [CHANNELS*WORD_W-1:0] frame_o,
    output logic                     commit_o,
    output logic                     diag_start_o
);
    localparam int FRAME_W = CHANNELS * WORD_W;

    logic     clk_q, latch_q;
    logic     rise, latch_fall, shift_en;
    ser_cmd_e cmd;
    cfg_t     cfg_q, cfg_view;
    logic     diag_q;
    logic              load_en;
    logic [WORD_W-1:0] load_data;
    logic [FRAME_W-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            clk_q   <= 1'b0;
            latch_q <= 1'b0;
        end else begin
            clk_q   <= ser_clk;
            latch_q <= ser_latch;
        end
    end

    assign rise       = ser_clk & ~clk_q;
    assign latch_fall = latch_q & ~ser_latch;
    assign shift_en   = rise & ~ser_latch;

    ledser_cmd_count #(.CW(CNT_W)) u_count (
        .clk        (clk),
        .rst        (rst),
        .latch_lvl  (ser_latch),
        .edge_rise  (rise),
        .latch_fall (latch_fall),
        .cmd_o      (cmd)
    );

    always_comb begin
        cfg_view       = cfg_q;
        cfg_view.therm = thermal_i;
    end

    assign load_en   = (cmd == CMD_RD_CFG) || (cmd == CMD_RD_HEALTH);
    assign load_data = (cmd == CMD_RD_CFG) ? WORD_W'(cfg_view) : WORD_W'(chan_good_i);

    ledser_shift #(.W(WORD_W), .CH(CHANNELS)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .long_mode (cfg_q.long_sr),
        .shift_en  (shift_en),
        .din       (ser_din),
        .load_en   (load_en),
        .load_data (load_data),
        .sr_o      (sr),
        .dout      (ser_dout)
    );

    ledser_gsbuf #(.W(WORD_W), .CH(CHANNELS)) u_gsbuf (
        .clk       (clk),
        .rst       (rst),
        .long_mode (cfg_q.long_sr),
        .store     (cmd == CMD_STORE),
        .publish   (cmd == CMD_PUBLISH),
        .word_in   (sr[WORD_W-1:0]),
        .frame_in  (sr),
        .frame_o   (frame_o),
        .commit_o  (commit_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= CFG_RESET;
            diag_q <= 1'b0;
        end else begin
            diag_q <= (cmd == CMD_DIAG);
            if (cmd == CMD_WR_CFG) begin
                cfg_q       <= cfg_t'(sr[15:0]);
                cfg_q.therm <= 1'b0;
            end else if (cmd == CMD_SHORT) begin
                cfg_q.long_sr <= 1'b0;
            end
        end
    end

    assign cfg_o        = 16'(cfg_view);
    assign diag_start_o = diag_q;

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cmd != CMD_WR_CFG && cmd != CMD_SHORT) |=> $stable(cfg_q)); // R12
    AST_SHORT_FORCED: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_SHORT) |=> !cfg_q.long_sr); // R10
    AST_DIAG_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        diag_start_o |=> !diag_start_o); // R9
    AST_THERM_LIVE: assert property (@(posedge clk) disable iff (rst)
        cfg_o[14] == thermal_i); // R11

endmodule

// File: tb/ledser_front_bench.sv
module ledser_front_bench;
    localparam int CH = 16;
    localparam int W  = 16;
    localparam int L  = CH * W;

    logic clk = 0, rst = 1;
    logic ser_clk = 0, ser_latch = 0, ser_din = 0;
    logic ser_dout;
    logic thermal_i = 0;
    logic [CH-1:0] chan_good_i = '1;
    logic [15:0] cfg_o;
    logic [L-1:0] frame_o;
    logic commit_o, diag_start_o;

    int total = 0, bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    ledser_front u_ledser_front (
        .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_latch(ser_latch),
        .ser_din(ser_din), .ser_dout(ser_dout), .thermal_i(thermal_i),
        .chan_good_i(chan_good_i), .cfg_o(cfg_o), .frame_o(frame_o),
        .commit_o(commit_o), .diag_start_o(diag_start_o)
    );

    // reference model state
    logic [L-1:0]         sr_m;
    logic [15:0]          cfg_m;      // bit 14 kept at 0
    logic [CH-1:0][W-1:0] buf_m;
    logic [L-1:0]         frame_m;
    int                   ptr_m;

    function automatic logic [15:0] cfg_seen();
        logic [15:0] v = cfg_m;
        v[14] = thermal_i;
        return v;
    endfunction

    function automatic logic exp_dout();
        return cfg_m[15] ? sr_m[L-1] : sr_m[W-1];
    endfunction

    function automatic string req_of(int n);
        case (n)
            1:       return "R3";
            2, 3:    return "R4";
            4, 5:    return "R7";
            6, 7:    return "R9";
            8, 9:    return "R8";
            10, 11:  return "R6";
            12, 13:  return "R10";
            default: return "R12";
        endcase
    endfunction

    task automatic chk(bit ok, string req, string what, logic [L-1:0] act, logic [L-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic send_bit(logic b);
        @(negedge clk);
        ser_din = b;
        ser_clk = 1;
        sr_m = {sr_m[L-2:0], b};
        @(negedge clk);
        ser_clk = 0;
        chk(ser_dout == exp_dout(), "R2", "serial out", L'(ser_dout), L'(exp_dout()));
    endtask

    task automatic send_word(logic [15:0] w);
        for (int i = 15; i >= 0; i--) send_bit(w[i]);
    endtask

    task automatic load_top(logic [15:0] v);
        if (cfg_m[15]) sr_m[L-1 -: W] = v;
        else           sr_m[W-1:0]    = v;
    endtask

    task automatic command(int n);
        bit exp_commit = 0, exp_diag = 0;
        string rq = req_of(n);
        @(negedge clk);
        ser_latch = 1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk) ser_clk = 1;
            @(negedge clk) ser_clk = 0;
        end
        @(negedge clk);
        ser_latch = 0;
        // model the decode on the next rising edge
        case (n)
            1: if (!cfg_m[15]) begin
                buf_m[ptr_m] = sr_m[W-1:0];
                ptr_m = (ptr_m == 0) ? CH - 1 : ptr_m - 1;
            end
            2, 3: begin
                if (cfg_m[15]) buf_m = sr_m;
                else           buf_m[ptr_m] = sr_m[W-1:0];
                frame_m = buf_m;
                ptr_m = CH - 1;
                exp_commit = 1;
            end
            4, 5:   load_top(cfg_seen());
            6, 7:   exp_diag = 1;
            8, 9:   load_top(chan_good_i);
            10, 11: begin cfg_m = sr_m[15:0]; cfg_m[14] = 1'b0; end
            12, 13: cfg_m[15] = 1'b0;
            default: ;
        endcase
        @(negedge clk);
        chk(commit_o == exp_commit, rq, "commit strobe", L'(commit_o), L'(exp_commit));
        chk(diag_start_o == exp_diag, rq, "diag strobe", L'(diag_start_o), L'(exp_diag));
        chk(cfg_o == cfg_seen(), rq, "config", L'(cfg_o), L'(cfg_seen()));
        chk(frame_o == frame_m, rq, "frame", frame_o, frame_m);
        chk(ser_dout == exp_dout(), rq, "serial out after command", L'(ser_dout), L'(exp_dout()));
        @(negedge clk);
        chk(!commit_o && !diag_start_o, rq, "strobes one cycle",
            L'({commit_o, diag_start_o}), '0);
    endtask

    initial begin
        fork
            begin
                repeat (190000) @(posedge clk);
                if (!done) begin
                    total++;
                    bad++;
                    $display("FAIL watchdog: actual=timeout expected=finish");
                    $display("  test done: total=%0d bad=%0d", total, bad);
                    $finish;
                end
            end
        join_none
    end

    initial begin
        void'($urandom(32'd20240611));
        sr_m = '0; cfg_m = 16'h06AC; buf_m = '0; frame_m = '0; ptr_m = CH - 1;
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R6 reset value
        chk(cfg_o == 16'h06AC, "R6", "reset config", L'(cfg_o), L'(16'h06AC));
        chk(frame_o == '0 && !commit_o && !diag_start_o && !ser_dout, "R6", "reset outputs",
            frame_o, '0);

        // R11: try to write thermal bit, then toggle live flag
        send_word(16'h4123);
        command(10);
        thermal_i = 1;
        @(negedge clk);
        chk(cfg_o == 16'h4123, "R11", "live thermal bit", L'(cfg_o), L'(16'h4123));
        thermal_i = 0;
        @(negedge clk);
        chk(cfg_o == 16'h0123, "R11", "live thermal cleared", L'(cfg_o), L'(16'h0123));

        // R3 / R4: sixteen words in short mode
        for (int c = 15; c >= 1; c--) begin
            send_word(16'h1000 * 16'(c) + 16'h0A5);
            command(1);
        end
        send_word(16'h00C3);
        command(2);

        // R8 health read, shifted out MSB first
        chan_good_i = 16'hA5C3;
        command(8);
        send_word(16'h0000);

        // R9 fault detection start
        command(6);
        command(7);

        // R12 ignored counts
        command(0);
        command(14);
        command(15);

        // R5 long mode: bit 15 set
        send_word(16'h8000 | 16'h06AC);
        command(11);
        for (int c = 15; c >= 0; c--) send_word(16'hB000 + 16'(c));
        send_bit(1'b0);              // first bit appears at the far end (R2)
        command(3);
        command(1);                  // R3: ignored in long mode
        command(4);                  // R7: config readback at top
        send_word(16'h0000);
        command(9);                  // R8 in long mode
        command(12);                 // R10 back to short
        command(5);

        // random mix
        for (int it = 0; it < 260; it++) begin
            int r = int'($urandom % 10);
            @(negedge clk);
            thermal_i = 1'($urandom);
            chan_good_i = 16'($urandom);
            if (r < 5) begin
                send_word(16'($urandom));
            end else if (r == 5) begin
                send_word(16'($urandom));
                command(10);
            end else begin
                command(int'($urandom % 16));
            end
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule